// File: doc/BRIEF.md
# Prioritized Timer Interrupt Vector

This block gathers the interrupt flags of the capture/compare channels numbered 1 and up, and the flag raised when the timer wraps, into one vector value. Channel 0 has its own dedicated interrupt and is not part of this block. Each source has a one-cycle set strobe and an enable bit. A source whose flag is pending and whose enable is high takes part in arbitration. The vector names the winning source with an even code, so a handler dispatcher can add the vector straight to its program counter and land in a jump table.

Reading the vector is destructive. A read strobe clears the flag of the source that the vector shows in that cycle, and no other flag. On the next cycle the vector moves to the next pending, enabled source, or to zero when none is left. The interrupt request is high whenever the vector is non-zero. A disabled source keeps its flag pending. It stays hidden from the vector until software enables it.

Top module: `tmr_ivec_top`

## Requirements
- R1: After reset every flag is clear, the vector reads 0 and the interrupt request is low.
- R2: A set strobe on a source makes its flag output high from the next clock edge onward, whatever that source's enable is.
- R3: The vector encoding is 0 when no enabled source is pending, 2·k for channel k (k = 1 to 4, giving 2, 4, 6 and 8) and 14 for the timer wrap flag. The flag output bit i of `chan_flag_o` belongs to channel i+1.
- R4: When several enabled sources are pending, channel 1 wins over channel 2, 2 over 3, 3 over 4, and any channel wins over the wrap flag.
- R5: A pending source whose enable is low is left out of the vector, and its flag stays set. Once its enable goes high it takes part in arbitration in the same cycle.
- R6: A read strobe while the vector is non-zero clears, at the next edge, exactly the flag of the source shown in the read cycle. The vector then shows the next pending enabled source.
- R7: A read strobe while the vector is 0 changes no flag.
- R8: If a set strobe for a source arrives in the same cycle as a read that reports that source, the flag stays set. A set strobe for any other source during a read is also kept.
- R9: The interrupt request output is high exactly when the vector is non-zero.
- R10: A pending flag stays set until a read that reports it. Neither time nor a change of enable clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_set_i | input | 4 | Per-channel flag set strobes, bit i = channel i+1 |
| chan_en_i | input | 4 | Per-channel interrupt enables, bit i = channel i+1 |
| wrap_set_i | input | 1 | Timer wrap flag set strobe |
| wrap_en_i | input | 1 | Timer wrap interrupt enable |
| rd_i | input | 1 | Vector read strobe, clears the reported flag |
| vec_o | output | 4 | Vector code of the highest-priority pending enabled source |
| irq_o | output | 1 | Interrupt request |
| chan_flag_o | output | 4 | Channel flags, bit i = channel i+1 |
| wrap_flag_o | output | 1 | Timer wrap flag |

## Verification
The hardest case to reach is a read that collides with a new set strobe. It is worst when the strobe is for the very source being reported, because the clear and the set then target one flag in one edge. The bench first raises a single channel flag. It then holds the read strobe and that channel's set strobe high in the same cycle, and checks that the flag and the vector both survive. A second collision sets a lower-priority channel during a read of a higher one. Disabled-but-pending flags are built up on purpose before reads, so that an idle read and late enables are both tested against hidden state.

// File: rtl/tmr_ivec_pkg.sv
package tmr_ivec_pkg;

    // Vector code for source index idx: channels use 2*(idx+1),
    // the index just above the channels is the timer wrap source.
    function automatic int unsigned src_code(input int unsigned idx,
                                             input int unsigned n_chan,
                                             input int unsigned wrap_code);
        if (idx < n_chan)
            return 2 * (idx + 1);
        else
            return wrap_code;
    endfunction

endpackage

// File: rtl/tmr_ivec_flags.sv
module tmr_ivec_flags #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o
);

    typedef struct packed {
        logic [NSRC-1:0] flag;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // a set strobe wins over a clear on the same bit
        state_d.flag = (state_q.flag & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign flag_o = state_q.flag;

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        assert_rise_needs_set_R2: assert property (
            @(posedge clk) disable iff (!rst_n)
            $rose(flag_o[g]) |-> $past(set_i[g]));

        assert_fall_needs_read_R10: assert property (
            @(posedge clk) disable iff (!rst_n)
            $fell(flag_o[g]) |-> ($past(clr_i[g]) && !$past(set_i[g])));
    end

endmodule

// File: rtl/tmr_ivec_pick.sv
module tmr_ivec_pick
    import tmr_ivec_pkg::*;
#(
    parameter int unsigned N_CHAN    = 4,
    parameter int unsigned WRAP_CODE = 14,
    parameter int unsigned VEC_W     = 4,
    localparam int unsigned NSRC     = N_CHAN + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req_i,
    input  logic             rd_i,
    output logic [VEC_W-1:0] vec_o,
    output logic [NSRC-1:0]  grant_o,
    output logic [NSRC-1:0]  clr_o
);

    typedef struct packed {
        logic [NSRC-1:0]  grant;
        logic [VEC_W-1:0] vec;
        logic             found;
    } pick_t;

    pick_t pick_d;

    always_comb begin
        pick_d = '0;
        // lowest index holds the highest priority
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && !pick_d.found) begin
                pick_d.grant[i] = 1'b1;
                pick_d.vec      = VEC_W'(src_code(i, N_CHAN, WRAP_CODE));
                pick_d.found    = 1'b1;
            end
        end
    end

    assign vec_o   = pick_d.vec;
    assign grant_o = pick_d.grant;
    assign clr_o   = rd_i ? pick_d.grant : '0;

    assert_single_grant_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_only_requested_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    assert_vec_when_requested_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (|req_i) |-> (vec_o != '0));

endmodule

// File: rtl/tmr_ivec_top.sv
module tmr_ivec_top #(
    parameter int unsigned N_CHAN    = 4,
    parameter int unsigned WRAP_CODE = 14,
    localparam int unsigned VEC_W    = $clog2(WRAP_CODE + 1),
    localparam int unsigned NSRC     = N_CHAN + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CHAN-1:0] chan_set_i,
    input  logic [N_CHAN-1:0] chan_en_i,
    input  logic              wrap_set_i,
    input  logic              wrap_en_i,
    input  logic              rd_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              irq_o,
    output logic [N_CHAN-1:0] chan_flag_o,
    output logic              wrap_flag_o
);

    logic [NSRC-1:0] set_all;
    logic [NSRC-1:0] en_all;
    logic [NSRC-1:0] flag_all;
    logic [NSRC-1:0] req_all;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] clr_all;

    assign set_all = {wrap_set_i, chan_set_i};
    assign en_all  = {wrap_en_i, chan_en_i};
    assign req_all = flag_all & en_all;

    tmr_ivec_flags #(
        .NSRC (NSRC)
    ) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_all),
        .clr_i  (clr_all),
        .flag_o (flag_all)
    );

    tmr_ivec_pick #(
        .N_CHAN    (N_CHAN),
        .WRAP_CODE (WRAP_CODE),
        .VEC_W     (VEC_W)
    ) i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_all),
        .rd_i    (rd_i),
        .vec_o   (vec_o),
        .grant_o (grant),
        .clr_o   (clr_all)
    );

    assign irq_o       = (vec_o != '0);
    assign chan_flag_o = flag_all[N_CHAN-1:0];
    assign wrap_flag_o = flag_all[N_CHAN];

    assert_irq_has_source_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(flag_all & en_all)));

    assert_idle_read_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_i && vec_o == '0 && set_all == '0) |=> $stable(flag_all));

    assert_read_clears_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_i && irq_o && ((grant & set_all) == '0))
            |=> ($countones(flag_all) < $countones($past(flag_all))
                 || $past(set_all) != '0));

endmodule

// File: tb/test_tmr_ivec_top.sv
`timescale 1ns/1ps
module test_tmr_ivec_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chan_set = '0;
    logic [3:0] chan_en = '0;
    logic       wrap_set = 1'b0;
    logic       wrap_en = 1'b0;
    logic       rd = 1'b0;
    logic [3:0] vec;
    logic       irq;
    logic [3:0] chan_flag;
    logic       wrap_flag;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tmr_ivec_top i_tmr_ivec_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_set_i  (chan_set),
        .chan_en_i   (chan_en),
        .wrap_set_i  (wrap_set),
        .wrap_en_i   (wrap_en),
        .rd_i        (rd),
        .vec_o       (vec),
        .irq_o       (irq),
        .chan_flag_o (chan_flag),
        .wrap_flag_o (wrap_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // irq must always follow the vector (R9)
    task automatic check_irq(input string tag);
        check({tag, " R9 irq"}, int'(irq), int'(vec != 0));
    endtask

    // inputs change right after a falling edge; checks follow 1 ns later
    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic set_pulse(input logic [3:0] ch, input logic wr);
        chan_set = ch;
        wrap_set = wr;
        tick();
        chan_set = '0;
        wrap_set = 1'b0;
    endtask

    task automatic read_vec(output int code);
        rd = 1'b1;
        #1;
        code = int'(vec);
        tick();
        rd = 1'b0;
        #1;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        chan_set = '0; chan_en = '0; wrap_set = 1'b0; wrap_en = 1'b0; rd = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset;
        do_reset();
        check("R1 vec", int'(vec), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 flags", int'({wrap_flag, chan_flag}), 0);
    endtask

    task automatic t_set_disabled;
        do_reset();
        set_pulse(4'b1010, 1'b1);
        check("R2 flags set while disabled", int'({wrap_flag, chan_flag}), 5'b11010);
        check("R5 vec hidden", int'(vec), 0);
        check_irq("R5");
        repeat (5) tick();
        check("R10 flags held", int'({wrap_flag, chan_flag}), 5'b11010);
        chan_en = 4'b1000;
        #1;
        check("R5 enable ch4 shows", int'(vec), 8);
        check_irq("R5 ch4");
        chan_en = 4'b0000;
        #1;
        check("R10 disable keeps flag", int'(chan_flag), 4'b1010);
    endtask

    task automatic t_encode;
        int code;
        do_reset();
        chan_en = 4'b1111;
        wrap_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            set_pulse(4'(1 << k), 1'b0);
            check($sformatf("R3 ch%0d code", k + 1), int'(vec), 2 * (k + 1));
            check_irq("R3");
            read_vec(code);
            check("R6 cleared single", int'(vec), 0);
        end
        set_pulse('0, 1'b1);
        check("R3 wrap code", int'(vec), 14);
        read_vec(code);
        check("R6 wrap cleared", int'(wrap_flag), 0);
    endtask

    task automatic t_priority;
        int code;
        int exp_seq[6] = '{2, 4, 6, 8, 14, 0};
        do_reset();
        chan_en = 4'b1111;
        wrap_en = 1'b1;
        set_pulse(4'b1111, 1'b1);
        for (int s = 0; s < 6; s++) begin
            check($sformatf("R4 order step %0d", s), int'(vec), exp_seq[s]);
            check_irq("R4");
            read_vec(code);
        end
        check("R6 all cleared", int'({wrap_flag, chan_flag}), 0);
        // exact clear: read ch2 with ch3 and wrap pending
        set_pulse(4'b0110, 1'b1);
        read_vec(code);
        check("R6 reported code", code, 4);
        check("R6 others untouched", int'({wrap_flag, chan_flag}), 5'b10100);
        check("R6 next shown", int'(vec), 6);
    endtask

    task automatic t_mask_priority;
        int code;
        do_reset();
        chan_en = 4'b0100;
        set_pulse(4'b0101, 1'b0);
        check("R5 higher disabled skipped", int'(vec), 6);
        read_vec(code);
        check("R5 disabled ch1 kept", int'(chan_flag), 4'b0001);
        check("R5 vec idle", int'(vec), 0);
        chan_en = 4'b0101;
        #1;
        check("R5 late enable", int'(vec), 2);
    endtask

    task automatic t_idle_read;
        int code;
        do_reset();
        set_pulse(4'b0011, 1'b1);
        read_vec(code);
        check("R7 idle read code", code, 0);
        check("R7 flags unchanged", int'({wrap_flag, chan_flag}), 5'b10011);
    endtask

    task automatic t_collide;
        int code;
        do_reset();
        chan_en = 4'b1111;
        set_pulse(4'b0001, 1'b0);
        chan_set = 4'b0001;
        read_vec(code);
        chan_set = '0;
        check("R8 same source code", code, 2);
        check("R8 same source kept", int'(chan_flag), 4'b0001);
        check("R8 vec still ch1", int'(vec), 2);
        chan_set = 4'b0100;
        read_vec(code);
        chan_set = '0;
        check("R8 other set kept", int'(chan_flag), 4'b0100);
        check("R8 vec ch3", int'(vec), 6);
        check_irq("R8");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_set_disabled();
                t_encode();
                t_priority();
                t_mask_priority();
                t_idle_read();
                t_collide();
            end
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule